// File: doc/BRIEF.md
# Folded Soft-Decision Viterbi Decoder

This block recovers the information bits of a rate 1/2, constraint length 7 convolutional code. The two code bits of each trellis step reach it as a pair of 4-bit soft samples, and it returns hard decisions. A branch metric stage scores the four possible code-bit pairs. A bank of 32 add-compare-select units then updates the 64 path metrics. Each unit handles two trellis states in turn: the state whose new bit is 0 in the first cycle, and the state whose new bit is 1 in the second. The bank is therefore half as wide as a fully parallel one, and each symbol takes two cycles.

After each step, the block writes one column of 64 survivor decision bits into a circular decision store. Once 61 symbols have arrived, every new symbol also triggers a walk back through the store. The walk starts at the state with the smallest metric, takes 60 steps, and releases the bit of the symbol 60 positions earlier. The input stalls during the walk. Output bits leave one per symbol, in arrival order, each marked by a single-cycle valid pulse. To get the final 60 bits out, the user appends 60 flush symbols.

Top module: `viterbi_fold_dec`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. State 0 starts with metric 0 and every other state starts with a larger metric.
- R2: A symbol is taken only on a cycle with `in_valid` and `in_ready` both 1. On the cycle after an accept, `in_ready` is 0, so no two symbols are taken less than 2 cycles apart.
- R3: Soft samples are offset binary, where 0 is the surest 0 and 15 the surest 1. `in_soft0` carries the code bit of generator 1111001 and `in_soft1` the code bit of generator 1011011. The MSB of each generator taps the current input bit and the LSB taps the oldest bit. The encoder starts in the all-zero state. With error-free input at full confidence, every decoded bit equals the encoded bit.
- R4: A single sample inverted to the opposite full-confidence value, with at least 30 symbols between such errors, is corrected.
- R5: Path metrics never wrap. When every metric has its MSB set, all metrics drop by half the range in the same update, so the smallest metric always stays below half the range. Long runs of weak (4 and 11) but correct samples still decode without error.
- R6: A sample at mid-scale (7), placed on every fifth symbol, does not cause a decoding error.
- R7: Output bit k appears only after symbol k+60 has been accepted. Bits come out in arrival order, exactly one for each accepted symbol beyond the first 60.
- R8: `out_valid` is never high for two cycles in a row.
- R9: A symbol that is held on the input while `in_ready` is 0 is taken once, when `in_ready` returns, and is neither lost nor repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A soft symbol pair is present |
| in_ready | output | 1 | The decoder takes the pair on this cycle if valid |
| in_soft0 | input | 4 | Soft sample for the first generator's code bit |
| in_soft1 | input | 4 | Soft sample for the second generator's code bit |
| out_valid | output | 1 | Single-cycle pulse marking a decoded bit |
| out_bit | output | 1 | Decoded information bit |

## Verification
The decoder first receives a run of all-zero symbols at full confidence. This shows that the start-state metrics and the trace-back latency line up, before any branch choice matters. Random full-confidence symbols then test the generator taps, the butterfly pairing of the units over their two cycles, and the decision bit order. A stretch with isolated inverted samples shows that compare-select picks the lower-metric survivor. The weak-but-correct run makes the minimum metric grow by 8 per symbol, so a wrong offset applied to the metrics would show up as output errors. The mid-scale erasures test ties and close comparisons. Random idle gaps and held-valid stalls exercise the handshake and the in-order release.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
    localparam int K    = 7;
    localparam int NST  = 1 << (K - 1);
    localparam int NACS = NST / 2;
    localparam logic [K-1:0] GEN_A = 7'b1111001;
    localparam logic [K-1:0] GEN_B = 7'b1011011;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HALF  = 2'd1,
        ST_TRACE = 2'd2
    } fsm_e;

    // window = {current bit, previous six bits (most recent at top)}
    function automatic logic [1:0] code_of(input logic [K-1:0] win);
        return {^(win & GEN_A), ^(win & GEN_B)};
    endfunction
endpackage

// File: rtl/vfd_bmu.sv
module vfd_bmu #(
    parameter int SOFT_W = 4,
    parameter int BM_W   = SOFT_W + 1
) (
    input  logic [SOFT_W-1:0]       s0,
    input  logic [SOFT_W-1:0]       s1,
    output logic [3:0][BM_W-1:0]    bm
);
    localparam int MAXV = (1 << SOFT_W) - 1;

    // index bit 1: expected first code bit, index bit 0: expected second
    for (genvar c = 0; c < 4; c++) begin : g_cw
        localparam bit EXP0 = ((c / 2) % 2) == 1;
        localparam bit EXP1 = (c % 2) == 1;
        logic [BM_W-1:0] d0, d1;
        assign d0 = EXP0 ? BM_W'(MAXV - int'(s0)) : BM_W'(s0);
        assign d1 = EXP1 ? BM_W'(MAXV - int'(s1)) : BM_W'(s1);
        assign bm[c] = d0 + d1;
    end
endmodule

// File: rtl/vfd_acs.sv
module vfd_acs #(
    parameter int PM_W = 8,
    parameter int BM_W = 5
) (
    input  logic [PM_W-1:0] pm_a,
    input  logic [PM_W-1:0] pm_b,
    input  logic [BM_W-1:0] bm_a,
    input  logic [BM_W-1:0] bm_b,
    output logic [PM_W-1:0] pm_o,
    output logic            dec
);
    logic [PM_W:0]   sum_a, sum_b;
    logic [PM_W-1:0] cand_a, cand_b;

    always_comb begin
        sum_a  = {1'b0, pm_a} + (PM_W + 1)'(bm_a);
        sum_b  = {1'b0, pm_b} + (PM_W + 1)'(bm_b);
        cand_a = sum_a[PM_W] ? '1 : sum_a[PM_W-1:0];
        cand_b = sum_b[PM_W] ? '1 : sum_b[PM_W-1:0];
        dec    = cand_b < cand_a;
        pm_o   = dec ? cand_b : cand_a;
    end
endmodule

// File: rtl/vfd_best.sv
module vfd_best #(
    parameter int NST  = 64,
    parameter int PM_W = 8,
    localparam int IW  = $clog2(NST)
) (
    input  logic [NST-1:0][PM_W-1:0] pm,
    output logic [IW-1:0]            idx
);
    logic [PM_W-1:0] low;

    always_comb begin
        idx = '0;
        low = pm[0];
        for (int i = 1; i < NST; i++) begin
            if (pm[i] < low) begin
                low = pm[i];
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/viterbi_fold_dec.sv
module viterbi_fold_dec #(
    parameter int SOFT_W = 4,
    parameter int PM_W   = 8,
    parameter int TB_LEN = 60,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SOFT_W-1:0] in_soft0,
    input  logic [SOFT_W-1:0] in_soft1,
    output logic              out_valid,
    output logic              out_bit
);
    import vfd_pkg::*;

    localparam int SB      = K - 1;
    localparam int BM_W    = SOFT_W + 1;
    localparam int MEM_D   = 1 << MEM_AW;
    localparam int PM_INIT = 1 << (PM_W - 2);
    localparam int CNT_W   = $clog2(TB_LEN + 2);
    localparam int STEP_W  = $clog2(TB_LEN);

    typedef struct packed {
        fsm_e                         fsm;
        logic [NST-1:0][PM_W-1:0]     pm;
        logic [NACS-1:0][PM_W-1:0]    half;
        logic [NACS-1:0]              dlo;
        logic [SOFT_W-1:0]            s0;
        logic [SOFT_W-1:0]            s1;
        logic [MEM_AW-1:0]            wptr;
        logic [MEM_AW-1:0]            rptr;
        logic [CNT_W-1:0]             seen;
        logic [STEP_W-1:0]            step;
        logic [SB-1:0]                st;
        logic                         ov;
        logic                         ob;
    } reg_t;

    reg_t r_q, r_d;

    logic [NST-1:0]              col_mem [MEM_D];
    logic [NST-1:0]              mem_rd;
    logic [NST-1:0]              mem_wdata;
    logic                        mem_we;
    logic                        phase_hi;
    logic [SOFT_W-1:0]           sel_s0, sel_s1;
    logic [3:0][BM_W-1:0]        bm;
    logic [NACS-1:0][PM_W-1:0]   acs_pm;
    logic [NACS-1:0]             acs_dec;
    logic [SB-1:0]               best_idx;
    logic [NST-1:0][PM_W-1:0]    full;
    logic [NST-1:0][PM_W-1:0]    pm_cur;
    logic                        all_hi;
    logic [SB-1:0]               tb_cur, tb_nxt;

    assign phase_hi = (r_q.fsm == ST_HALF);
    assign sel_s0   = phase_hi ? r_q.s0 : in_soft0;
    assign sel_s1   = phase_hi ? r_q.s1 : in_soft1;
    assign mem_rd   = col_mem[r_q.rptr];
    assign pm_cur   = r_q.pm;

    vfd_bmu #(.SOFT_W(SOFT_W), .BM_W(BM_W)) u_bmu (
        .s0 (sel_s0),
        .s1 (sel_s1),
        .bm (bm)
    );

    // unit j serves predecessors 2j and 2j+1; new state j (bit 0) then j+NACS (bit 1)
    for (genvar j = 0; j < NACS; j++) begin : g_acs
        localparam logic [K-1:0] WA0 = K'(2 * j);
        localparam logic [K-1:0] HI  = K'(1 << (K - 1));
        localparam logic [1:0] CA0 = code_of(WA0);
        localparam logic [1:0] CB0 = code_of(WA0 | K'(1));
        localparam logic [1:0] CA1 = code_of(WA0 | HI);
        localparam logic [1:0] CB1 = code_of(WA0 | HI | K'(1));
        logic [BM_W-1:0] bma, bmb;
        assign bma = phase_hi ? bm[CA1] : bm[CA0];
        assign bmb = phase_hi ? bm[CB1] : bm[CB0];
        vfd_acs #(.PM_W(PM_W), .BM_W(BM_W)) u_acs (
            .pm_a (r_q.pm[2*j]),
            .pm_b (r_q.pm[2*j+1]),
            .bm_a (bma),
            .bm_b (bmb),
            .pm_o (acs_pm[j]),
            .dec  (acs_dec[j])
        );
    end

    vfd_best #(.NST(NST), .PM_W(PM_W)) u_best (
        .pm  (r_q.pm),
        .idx (best_idx)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ov    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        full      = '0;
        all_hi    = 1'b1;
        tb_cur    = '0;
        tb_nxt    = '0;
        case (r_q.fsm)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.half = acs_pm;
                    r_d.dlo  = acs_dec;
                    r_d.s0   = in_soft0;
                    r_d.s1   = in_soft1;
                    r_d.fsm  = ST_HALF;
                end
            end
            ST_HALF: begin
                for (int i = 0; i < NACS; i++) begin
                    full[i]        = r_q.half[i];
                    full[i + NACS] = acs_pm[i];
                end
                for (int i = 0; i < NST; i++) all_hi = all_hi & full[i][PM_W-1];
                // every metric in upper half: take half the range off all of them
                if (all_hi) begin
                    for (int i = 0; i < NST; i++) full[i][PM_W-1] = 1'b0;
                end
                r_d.pm    = full;
                mem_we    = 1'b1;
                mem_wdata = {acs_dec, r_q.dlo};
                r_d.rptr  = r_q.wptr;
                r_d.wptr  = r_q.wptr + MEM_AW'(1);
                if (int'(r_q.seen) < TB_LEN + 1) r_d.seen = r_q.seen + CNT_W'(1);
                if (int'(r_q.seen) + 1 >= TB_LEN + 1) begin
                    r_d.fsm  = ST_TRACE;
                    r_d.step = '0;
                end else begin
                    r_d.fsm = ST_IDLE;
                end
            end
            ST_TRACE: begin
                tb_cur   = (r_q.step == '0) ? best_idx : r_q.st;
                tb_nxt   = {tb_cur[SB-2:0], mem_rd[tb_cur]};
                r_d.st   = tb_nxt;
                r_d.rptr = r_q.rptr - MEM_AW'(1);
                r_d.step = r_q.step + STEP_W'(1);
                if (int'(r_q.step) == TB_LEN - 1) begin
                    r_d.ov  = 1'b1;
                    r_d.ob  = tb_nxt[SB-1];
                    r_d.fsm = ST_IDLE;
                end
            end
            default: r_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
            for (int i = 1; i < NST; i++) r_q.pm[i] <= PM_W'(PM_INIT);
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) col_mem[r_q.wptr] <= mem_wdata;
    end

    assign in_ready  = (r_q.fsm == ST_IDLE);
    assign out_valid = r_q.ov;
    assign out_bit   = r_q.ob;
endmodule

// File: rtl/vfd_chk.sv
module vfd_chk #(
    parameter int NST    = 64,
    parameter int PM_W   = 8,
    parameter int TB_LEN = 60
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic [NST-1:0][PM_W-1:0] pm
);
    logic [31:0]    acc_q, outs_q;
    logic [NST-1:0] pm_msb;

    always_comb begin
        for (int i = 0; i < NST; i++) pm_msb[i] = pm[i][PM_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            outs_q <= '0;
        end else begin
            if (in_valid && in_ready) acc_q <= acc_q + 32'd1;
            if (out_valid) outs_q <= outs_q + 32'd1;
        end
    end

    // R1
    reset_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    // R2
    single_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R5
    pm_range_chk: assert property (@(posedge clk) disable iff (rst)
        !(&pm_msb));

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (acc_q >= outs_q + 32'(TB_LEN + 1)));

    // R8
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
endmodule

bind viterbi_fold_dec vfd_chk #(
    .NST    (vfd_pkg::NST),
    .PM_W   (PM_W),
    .TB_LEN (TB_LEN)
) u_vfd_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .pm        (pm_cur)
);

// File: tb/test_viterbi_fold_dec.sv
module test_viterbi_fold_dec;
    localparam int NSYM = 550;
    localparam int TBL  = 60;
    localparam int NOUT = NSYM - TBL;
    localparam logic [6:0] GA = 7'b1111001;
    localparam logic [6:0] GB = 7'b1011011;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_soft0 = '0;
    logic [3:0] in_soft1 = '0;
    logic       in_ready, out_valid, out_bit;

    int bits [NSYM];
    int sa   [NSYM];
    int sb   [NSYM];
    int checks = 0, fails = 0, acc = 0, outs = 0, cyc = 0, last_acc = -10;

    always #5 clk = ~clk;

    viterbi_fold_dec i_viterbi_fold_dec (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_soft0  (in_soft0),
        .in_soft1  (in_soft1),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic string tag_of(int k);
        if (k >= 200 && k < 320) return "R4 corrected flip";
        if (k >= 320 && k < 420) return "R5 weak run";
        if (k >= 420 && k < 480) return "R6 erasure";
        return "R3 clean decode";
    endfunction

    // build stimulus: behavioural encoder, state st[5] is most recent bit
    initial begin
        logic [5:0] st;
        st = '0;
        for (int i = 0; i < NSYM; i++) begin
            logic [6:0] w;
            int c0, c1, hi, lo;
            if (i < 80 || i >= 480) bits[i] = 0;
            else bits[i] = int'($urandom_range(0, 1));
            w  = {bits[i][0], st};
            c0 = int'(^(w & GA));
            c1 = int'(^(w & GB));
            st = {bits[i][0], st[5:1]};
            hi = (i >= 320 && i < 420) ? 11 : 15;
            lo = (i >= 320 && i < 420) ? 4 : 0;
            sa[i] = c0 ? hi : lo;
            sb[i] = c1 ? hi : lo;
            if (i >= 200 && i < 320 && (i % 30) == 15) sa[i] = 15 - sa[i];
            if (i >= 420 && i < 480 && (i % 5) == 0) sb[i] = 7;
        end
    end

    // monitor, sampled just after the falling edge
    always @(negedge clk) begin
        #1;
        cyc++;
        if (!rst) begin
            if (out_valid) begin
                if (outs < NOUT) begin
                    check(out_bit == bits[outs][0], tag_of(outs), int'(out_bit), bits[outs]);
                    // R7 latency: symbol outs+60 must already be taken
                    check(acc >= outs + TBL + 1, "R7 latency", acc, outs + TBL + 1);
                end else begin
                    check(1'b0, "R7 extra output", outs, NOUT - 1);
                end
                outs++;
            end
            if (in_valid && in_ready) begin
                // R2 spacing between accepts
                check(cyc - last_acc >= 2, "R2 accept spacing", cyc - last_acc, 2);
                last_acc = cyc;
                acc++;
            end
        end
        if (cyc > 150000) begin
            check(1'b0, "R7 watchdog expired", outs, NOUT);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 no output after reset", int'(out_valid), 0);
        for (int i = 0; i < NSYM; i++) begin
            int gap;
            gap = int'($urandom_range(0, 2));
            @(negedge clk);
            repeat (gap) @(negedge clk);
            in_valid = 1'b1;
            in_soft0 = 4'(sa[i]);
            in_soft1 = 4'(sb[i]);
            // R9: hold the symbol until the decoder is ready
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
        while (outs < NOUT) @(negedge clk);
        repeat (200) @(negedge clk);
        check(outs == NOUT, "R7 output count", outs, NOUT);
        check(acc == NSYM, "R9 accepted count", acc, NSYM);
        summary();
    end
endmodule